// File: doc/BRIEF.md
# Serial ADC Command Master

This block drives an external SPI- or Microwire-style analog-to-digital converter through a small register window. Software starts a transfer with a single command word written to the data register. The word holds three fields: the configuration byte to send, the packet length in serial clocks, and a start flag. The block then lowers the chip select and runs the serial clock. It sends the configuration byte most significant bit first while it collects the converter's reply on the input line.

A busy flag in a separate status register stays set for the whole packet. When the flag clears, reading the data register returns the last byte captured. A full conversion is normally three packets in a row. The byte from the first packet is thrown away, and the bytes from the second and third packets form the result.

The serial clock is divided down from the system clock by a parameter. Two mode inputs select the sampling edge. By default the reply is sampled on the rising serial clock edge, which suits a converter clocked externally. When both the extended-mode input and the negative-edge input are high, the reply is sampled on the falling edge instead.

Top module: `adc_serial_master`

## Requirements
- R1: A write to the data register (offset 0x500) with bit 14 set, a nonzero length and no transfer in progress starts a packet. Chip select is low and the busy flag is set from the next clock onward.
- R2: Bits 13:8 of the command give the number of serial clock periods in the packet. Each period lasts 2*DIV_HALF system clocks, low for the first half and high for the second. The busy flag stays set for exactly 2*DIV_HALF*length system clocks. The serial clock is low whenever chip select is high.
- R3: The data output carries command bits 7:0 most significant bit first, one bit per serial clock period. Every period after the eighth carries 0. The output changes only where the serial clock falls.
- R4: With either mode input low, the input line is sampled on each rising serial clock edge.
- R5: With both the extended-mode and negative-edge inputs high when the packet starts, the input line is sampled on each falling serial clock edge instead.
- R6: Reading the data register returns the last eight sampled bits in bits 7:0, with the earliest of them in bit 7. A packet of fewer than eight clocks leaves the unfilled upper bits at 0. Bits 31:8 read 0. The byte changes only when a packet ends.
- R7: The status register (offset 0x140) shows busy in bit 26, and all its other bits read 0. Chip select rises and busy clears on the same clock, right after the last serial clock falling edge.
- R8: A command written while a packet is in progress is ignored. The running packet keeps its length, its output bits and its result.
- R9: A command with bit 14 clear, or with a length of 0, starts nothing. Chip select stays high and busy stays clear.
- R10: After reset, chip select is high, the serial clock and the data output are low, busy is clear and the data register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| ext_mode | input | 1 | Extended timing mode select |
| neg_edge | input | 1 | Falling-edge sampling select, used with ext_mode |
| miso_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| mosi_o | output | 1 | Serial data to the converter |
| cs_n_o | output | 1 | Chip select, active low |

## Verification
The bench builds the block with DIV_HALF = 2, so one serial clock period is four system clocks. At that size every packet length from 1 to 24 can be swept in both sampling modes, along with the 63-clock maximum, in a few thousand cycles. The bench's converter model changes its output on every serial clock edge from a random pattern. Rising-edge and falling-edge sampling therefore pick different bits, and the expected byte is computed from the pattern index. The small divider also places a command written during a packet only a few clocks after the start, well inside the packet.

// File: rtl/adcsm_pkg.sv
package adcsm_pkg;
   localparam int unsigned CFG_W    = 8;
   localparam int unsigned LEN_LSB  = 8;
   localparam int unsigned LEN_W    = 6;
   localparam int unsigned EN_BIT   = 14;
   localparam int unsigned BUSY_BIT = 26;

   typedef struct packed {
      logic [CFG_W-1:0] cfg;
      logic [LEN_W-1:0] len;
   } adcsm_cmd_t;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } adcsm_state_e;
endpackage

// File: rtl/adcsm_regif.sv
module adcsm_regif
   import adcsm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DATA_OFS = 12'h500,
   parameter int unsigned STAT_OFS = 12'h140
) (
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              busy,
   input  logic [CFG_W-1:0]  rx_byte,
   output logic              start,
   output adcsm_cmd_t        cmd,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   initial begin
      if (DATA_W <= BUSY_BIT) $error("DATA_W too narrow for the busy bit");
      if (DATA_A == STAT_A)   $error("register offsets collide");
   end

   logic unused_wbits;
   assign unused_wbits = ^reg_wdata[DATA_W-1:EN_BIT+1];

   assign cmd.cfg = reg_wdata[CFG_W-1:0];
   assign cmd.len = reg_wdata[LEN_LSB +: LEN_W];

   assign start = reg_we && (reg_addr == DATA_A) && reg_wdata[EN_BIT]
                  && (cmd.len != '0) && !busy;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == DATA_A)      reg_rdata[CFG_W-1:0] = rx_byte;
      else if (reg_addr == STAT_A) reg_rdata[BUSY_BIT]  = busy;
   end
endmodule

// File: rtl/adcsm_div.sv
module adcsm_div #(
   parameter int unsigned DIV_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   initial begin
      if (DIV_HALF < 1) $error("DIV_HALF must be at least 1");
   end

   generate
      if (DIV_HALF == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CNT_W = $clog2(DIV_HALF);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_HALF - 1);
         logic [CNT_W-1:0] cnt;
         assign tick = run && (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (!run)   cnt <= '0;
            else if (tick)   cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/adcsm_shift.sv
module adcsm_shift
   import adcsm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  adcsm_cmd_t       cmd,
   input  logic             neg_sel,
   input  logic             miso,
   input  logic             tick,
   output logic             busy,
   output logic             sclk,
   output logic             mosi,
   output logic [CFG_W-1:0] rx_byte
);
   adcsm_state_e     state;
   logic [CFG_W-1:0] tx_sr, rx_sr, rx_nxt;
   logic [LEN_W-1:0] bit_cnt;
   logic             neg_q;

   assign busy   = (state == ST_RUN);
   assign mosi   = busy & tx_sr[CFG_W-1];
   assign rx_nxt = {rx_sr[CFG_W-2:0], miso};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         sclk    <= 1'b0;
         tx_sr   <= '0;
         rx_sr   <= '0;
         rx_byte <= '0;
         bit_cnt <= '0;
         neg_q   <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_RUN;
                  tx_sr   <= cmd.cfg;
                  rx_sr   <= '0;
                  bit_cnt <= cmd.len;
                  neg_q   <= neg_sel;
                  sclk    <= 1'b0;
               end
            end
            ST_RUN: begin
               if (tick) begin
                  if (!sclk) begin
                     sclk <= 1'b1;
                     if (!neg_q) rx_sr <= rx_nxt;
                  end else begin
                     sclk    <= 1'b0;
                     if (neg_q) rx_sr <= rx_nxt;
                     tx_sr   <= {tx_sr[CFG_W-2:0], 1'b0};
                     bit_cnt <= bit_cnt - 1'b1;
                     if (bit_cnt == LEN_W'(1)) begin
                        state   <= ST_IDLE;
                        rx_byte <= neg_q ? rx_nxt : rx_sr;
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master
   import adcsm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned DATA_OFS = 12'h500,
   parameter int unsigned STAT_OFS = 12'h140,
   parameter int unsigned DIV_HALF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              ext_mode,
   input  logic              neg_edge,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              cs_n_o
);
   initial begin
      if (ADDR_W < 12) $error("ADDR_W must reach the register offsets");
   end

   logic             start, busy, tick;
   adcsm_cmd_t       cmd;
   logic [CFG_W-1:0] rx_byte;

   adcsm_regif #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .DATA_OFS(DATA_OFS), .STAT_OFS(STAT_OFS)
   ) u_regif (
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .busy(busy), .rx_byte(rx_byte),
      .start(start), .cmd(cmd), .reg_rdata(reg_rdata)
   );

   adcsm_div #(.DIV_HALF(DIV_HALF)) u_div (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
   );

   adcsm_shift u_shift (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
      .neg_sel(ext_mode & neg_edge), .miso(miso_i), .tick(tick),
      .busy(busy), .sclk(sclk_o), .mosi(mosi_o), .rx_byte(rx_byte)
   );

   assign cs_n_o = ~busy;
endmodule

// File: rtl/adcsm_chk.sv
module adcsm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       sclk_o,
   input logic       mosi_o,
   input logic       cs_n_o,
   input logic [7:0] rx_byte
);
   p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> cs_n_o);

   p_start_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !cs_n_o);

   p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !sclk_o);

   p_mosi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

   p_mosi_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> !mosi_o);

   p_rx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(cs_n_o) |-> $stable(rx_byte));

   p_end_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> $past(sclk_o));
endmodule

bind adc_serial_master adcsm_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .sclk_o(sclk_o),
   .mosi_o(mosi_o), .cs_n_o(cs_n_o), .rx_byte(rx_byte)
);

// File: tb/test_adc_serial_master.sv
module test_adc_serial_master;
   localparam int DIV = 2;
   localparam logic [11:0] DATA_A = 12'h500;
   localparam logic [11:0] STAT_A = 12'h140;

   logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ext_mode = 1'b0, neg_edge = 1'b0, miso = 1'b0;
   logic        sclk_o, mosi_o, cs_n_o;

   int checks = 0, errors = 0;
   logic [127:0] pat = '0;
   int ecnt = 0, rises = 0;
   logic [63:0] mosi_rec = '0;

   adc_serial_master #(.DIV_HALF(DIV)) i_adc_serial_master (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_mode(ext_mode),
      .neg_edge(neg_edge), .miso_i(miso), .sclk_o(sclk_o),
      .mosi_o(mosi_o), .cs_n_o(cs_n_o)
   );

   always #10 clk = ~clk;

   // converter model: new pattern bit on every serial clock edge
   always @(posedge sclk_o or negedge sclk_o) begin
      #1;
      ecnt = ecnt + 1;
      miso = pat[ecnt[6:0]];
   end

   always @(posedge sclk_o) begin
      mosi_rec[rises[5:0]] = mosi_o;
      rises = rises + 1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   // one packet; intrude != 0 writes another command part way through (R8)
   task automatic xfer(input logic [7:0] cfg, input int len, input bit negm, input bit intrude);
      logic [31:0] st, d;
      logic [63:0] exp_mosi;
      logic [7:0]  exp_rx;
      int busyc;
      pat = {$urandom, $urandom, $urandom, $urandom};
      ecnt = 0; miso = pat[0]; rises = 0; mosi_rec = '0;
      wr(DATA_A, 32'h4000 | (32'(len) << 8) | 32'(cfg));
      busyc = 0;
      rd(STAT_A, st);
      chk("R7 status word while busy", 64'(st), 64'h0400_0000);
      while (st[26] && busyc < 5000) begin
         busyc++;
         if (intrude && busyc == 5) begin
            reg_addr = DATA_A; reg_wdata = 32'h4000 | (32'd3 << 8) | 32'h5A;
            reg_we = 1'b1;
            @(negedge clk);
            reg_we = 1'b0;
         end else begin
            @(negedge clk);
         end
         rd(STAT_A, st);
      end
      chk(intrude ? "R8 busy length kept" : "R2 busy length", 64'(busyc), 64'(2*DIV*len));
      chk("R2 serial clock count", 64'(rises), 64'(len));
      chk("R7 chip select high at end", 64'(cs_n_o), 64'd1);
      exp_mosi = '0;
      for (int i = 0; i < len; i++) exp_mosi[i] = (i < 8) ? cfg[7-i] : 1'b0;
      chk(intrude ? "R8 output bits kept" : "R3 output bits", mosi_rec, exp_mosi);
      exp_rx = '0;
      for (int i = 0; i < len; i++) exp_rx = {exp_rx[6:0], pat[negm ? 2*i+1 : 2*i]};
      rd(DATA_A, d);
      chk(negm ? "R5 falling-edge byte" : "R4 R6 rising-edge byte", 64'(d), 64'(exp_rx));
   endtask

   task automatic no_start(input logic [31:0] w, input string req);
      logic [31:0] st;
      rises = 0;
      wr(DATA_A, w);
      for (int k = 0; k < 12; k++) begin
         rd(STAT_A, st);
         chk(req, {62'd0, cs_n_o, st[26]}, 64'd2);
         @(negedge clk);
      end
      chk(req, 64'(rises), 64'd0);
   endtask

   initial begin
      #(20*150000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10 chip select", 64'(cs_n_o), 64'd1);
      chk("R10 serial clock", 64'(sclk_o), 64'd0);
      chk("R10 data out", 64'(mosi_o), 64'd0);
      rd(STAT_A, d); chk("R10 status", 64'(d), 64'd0);
      rd(DATA_A, d); chk("R10 data reg", 64'(d), 64'd0);

      // R1 R2 R3 R4 R6: default mode sweep of lengths
      for (int l = 1; l <= 24; l++) xfer(8'((l*37 + 8'h83) & 8'hFF), l, 1'b0, 1'b0);
      xfer(8'hA5, 63, 1'b0, 1'b0);

      // R4: extended mode alone keeps rising-edge sampling
      ext_mode = 1'b1;
      xfer(8'h83, 24, 1'b0, 1'b0);
      xfer(8'h3C, 5, 1'b0, 1'b0);

      // R5: extended + negative edge sweep
      neg_edge = 1'b1;
      for (int l = 1; l <= 24; l++) xfer(8'((l*91 + 8'h11) & 8'hFF), l, 1'b1, 1'b0);
      ext_mode = 1'b0;
      xfer(8'hC3, 12, 1'b0, 1'b0);
      neg_edge = 1'b0;

      // R6: three-packet conversion sequence
      for (int p = 0; p < 3; p++) xfer(8'h83, 24, 1'b0, 1'b0);

      // R8: command during a packet is ignored
      xfer(8'hE1, 20, 1'b0, 1'b1);

      // R9: no enable, zero length
      no_start(32'h0000_1883, "R9 enable clear");
      no_start(32'h0000_4083, "R9 zero length");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule